// File: doc/BRIEF.md
# Service Shell Command Sequencer

This block sits behind a transport layer that has already reassembled single service frames. Each frame reaches it one byte per cycle, and the first byte carries the total frame length. The block reads the opcode and checks it against a privilege ladder. It sends back one or two response bytes. Along the way it drives side effects for each command: it latches a register pair, forwards the key bytes to an external authentication engine, asks for a challenge, writes payload bytes into a fixed staging RAM window, starts verification of the staged image, or requests a soft reset.

The ladder runs as follows. Elevation moves the block from idle (0) to elevated (2). A challenge request, allowed only after a minimum uptime, moves it to challenged (3). A key that passes moves it to authorised (4), and only in that state can RAM writes and image launch be used. A coded exit command moves the block to the terminal state 0xA and raises a soft-reset request. A keepalive is answered in every state.

Top module: `svc_shell`

## Requirements
- R1: Opcode 0x6B with frame length 1 is answered with the two bytes 0xA0, 0x02 in every state, and the state does not change.
- R2: Opcode 0x30 in state 0 with frame length of at least 9 answers 0xA0 and moves to state 2. Payload bytes 1..4 go to `cfg_w0_o` and bytes 5..8 go to `cfg_w1_o`, with the first byte as the MSB. Extra bytes are ignored.
- R3: Opcode 0x54 with length 1 is accepted only in state 2 and only after at least 100 `tick_i` pulses since reset. It then answers 0xA0, pulses `chal_req_o` for one cycle and moves to state 3. With 99 ticks it is answered 0xE1.
- R4: Opcode 0x65 is accepted only in state 3 with exactly 256 payload bytes. Each payload byte appears on `key_valid_o`/`key_byte_o`, and `auth_check_o` then pulses once. On `auth_done_i` the block answers 0xA0 and moves to state 4 if `auth_pass_i` is high. Otherwise it answers 0xE3 and moves back to state 2.
- R5: Opcode 0x78 in state 4 carries a 4-byte big-endian offset followed by N data bytes. Data byte i is written to address 0xB0010000 + offset + i, and the command answers 0xA0.
- R6: A 0x78 whose offset + N exceeds 0x5000 is answered 0xE2 and performs no write. offset + N equal to 0x5000 is accepted.
- R7: Opcode 0x79 with length 1 in state 4 answers 0xA0 and pulses `verify_start_o` for one cycle.
- R8: Opcode 0x7D with length 4, in any state but 0xA, answers 0xA0. If its three payload bytes are 0x41 0x43 0x57, the state becomes 0xA and `rst_req_o` pulses once with `rst_reason_o` = 0x200. Any other code leaves the state unchanged.
- R9: An unknown opcode, a wrong length, or a command not legal in the current state is answered with the single byte 0xE1 and leaves the state unchanged.
- R10: Opcodes 0x78 and 0x79 are legal only in state 4.
- R11: After reset the state is 0, the strobes are low, and the latched words and reset reason are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Frame byte valid |
| in_first_i | input | 1 | Marks the opcode byte of a frame |
| in_len_i | input | 12 | Total frame length in bytes, valid with the first byte |
| in_byte_i | input | 8 | Frame byte |
| tick_i | input | 1 | Uptime tick |
| auth_done_i | input | 1 | Authentication engine result strobe |
| auth_pass_i | input | 1 | Authentication result, valid with auth_done_i |
| rsp_valid_o | output | 1 | Response byte valid |
| rsp_byte_o | output | 8 | Response byte |
| key_valid_o | output | 1 | Key byte valid toward the authentication engine |
| key_byte_o | output | 8 | Key byte |
| auth_check_o | output | 1 | Key complete, start comparison |
| chal_req_o | output | 1 | Challenge generation request |
| ram_we_o | output | 1 | Staging RAM write strobe |
| ram_addr_o | output | 32 | Staging RAM byte address |
| ram_wdata_o | output | 8 | Staging RAM write data |
| cfg_w0_o | output | 32 | First latched payload word |
| cfg_w1_o | output | 32 | Second latched payload word |
| rst_req_o | output | 1 | Soft reset request pulse |
| rst_reason_o | output | 16 | Soft reset reason code |
| verify_start_o | output | 1 | Start checksum and signature verification |

## Verification
The assertions rely on two properties of the inputs. First, every frame arrives as an unbroken run of `in_len_i` bytes, and `in_len_i` is at least 1. Second, no new frame and no `auth_done_i` arrives while a key comparison is outstanding, except the one result that ends it. The bench's frame task drives each frame on consecutive cycles and leaves the bus idle afterwards until the response has drained. The authentication engine model raises `auth_done_i` only after it has seen `auth_check_o`. Ticks are driven only between frames, so the uptime threshold is crossed at a known point.

// File: rtl/svc_pkg.sv
package svc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE = 4'h0,
    ST_ELEV = 4'h2,
    ST_CHAL = 4'h3,
    ST_AUTH = 4'h4,
    ST_EXIT = 4'hA
  } svc_state_e;

  localparam logic [7:0] OP_KEEP = 8'h6B;
  localparam logic [7:0] OP_ELEV = 8'h30;
  localparam logic [7:0] OP_CHAL = 8'h54;
  localparam logic [7:0] OP_KEY  = 8'h65;
  localparam logic [7:0] OP_EXIT = 8'h7D;
  localparam logic [7:0] OP_WR   = 8'h78;
  localparam logic [7:0] OP_RUN  = 8'h79;

  localparam logic [7:0] RSP_ACK   = 8'hA0;
  localparam logic [7:0] RSP_ALIVE = 8'h02;
  localparam logic [7:0] NRC_BAD   = 8'hE1;
  localparam logic [7:0] NRC_RANGE = 8'hE2;
  localparam logic [7:0] NRC_AUTH  = 8'hE3;
endpackage

// File: rtl/svc_uptime.sv
module svc_uptime #(
  parameter int MIN_TICKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic up_ok_o
);
  localparam int CW = $clog2(MIN_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
  end

  assign up_ok_o = (cnt_q == LIMIT);

  AST_UP_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_ok_o |=> up_ok_o); // R3
endmodule

// File: rtl/svc_win.sv
module svc_win #(
  parameter logic [31:0] WIN_BASE = 32'hB001_0000,
  parameter logic [31:0] WIN_SIZE = 32'h0000_5000,
  parameter int          LW       = 12
) (
  input  logic [31:0]   off_i,
  input  logic [LW-1:0] dlen_i,
  input  logic [LW-1:0] idx_i,
  output logic          fit_o,
  output logic [31:0]   addr_o
);
  logic [32:0] span;

  // 33-bit sum so a huge offset cannot wrap into the window
  assign span   = {1'b0, off_i} + 33'(dlen_i);
  assign fit_o  = span <= {1'b0, WIN_SIZE};
  assign addr_o = WIN_BASE + off_i + 32'(idx_i);
endmodule

// File: rtl/svc_rsp.sv
module svc_rsp (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       two_i,
  input  logic [7:0] b0_i,
  input  logic [7:0] b1_i,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_byte_o
);
  logic       pend_q;
  logic [7:0] b1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      b1_q        <= '0;
      rsp_valid_o <= 1'b0;
      rsp_byte_o  <= '0;
    end else if (load_i) begin
      rsp_valid_o <= 1'b1;
      rsp_byte_o  <= b0_i;
      pend_q      <= two_i;
      b1_q        <= b1_i;
    end else if (pend_q) begin
      rsp_valid_o <= 1'b1;
      rsp_byte_o  <= b1_q;
      pend_q      <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
    end
  end

  AST_RSP_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_byte_o == 8'h02) |-> $past(rsp_valid_o)); // R1
endmodule

// File: rtl/svc_fsm.sv
module svc_fsm
  import svc_pkg::*;
#(
  parameter int          LW         = 12,
  parameter int          KEY_BYTES  = 256,
  parameter logic [31:0] WIN_BASE   = 32'hB001_0000,
  parameter logic [31:0] WIN_SIZE   = 32'h0000_5000,
  parameter logic [23:0] EXIT_CODE  = 24'h414357,
  parameter logic [15:0] RST_REASON = 16'h0200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          in_first_i,
  input  logic [LW-1:0] in_len_i,
  input  logic [7:0]    in_byte_i,
  input  logic          auth_done_i,
  input  logic          auth_pass_i,
  input  logic          up_ok_i,
  input  logic          win_fit_i,
  input  logic [31:0]   win_addr_i,
  output logic [31:0]   win_off_o,
  output logic [LW-1:0] win_dlen_o,
  output logic [LW-1:0] win_idx_o,
  output logic          rsp_ld_o,
  output logic          rsp_two_o,
  output logic [7:0]    rsp_b0_o,
  output logic [7:0]    rsp_b1_o,
  output logic          key_valid_o,
  output logic [7:0]    key_byte_o,
  output logic          auth_check_o,
  output logic          chal_req_o,
  output logic          ram_we_o,
  output logic [31:0]   ram_addr_o,
  output logic [7:0]    ram_wdata_o,
  output logic [31:0]   cfg_w0_o,
  output logic [31:0]   cfg_w1_o,
  output logic          rst_req_o,
  output logic [15:0]   rst_reason_o,
  output logic          verify_start_o
);
  localparam logic [LW-1:0] KEY_LEN = LW'(KEY_BYTES + 1);
  localparam logic [LW-1:0] ONE     = LW'(1);
  localparam logic [LW-1:0] OFF_END = LW'(4);
  localparam logic [LW-1:0] DAT_BEG = LW'(5);
  localparam logic [LW-1:0] SH_END  = LW'(8);
  localparam logic [LW-1:0] ELEV_MIN = LW'(9);

  svc_state_e    st_q, st_d;
  logic [7:0]    op_q;
  logic [LW-1:0] len_q, cnt_q;
  logic          ok_q, wr_ok_q, wait_q, wait_d;
  logic [63:0]   sh_q, sh_next;
  logic [31:0]   off_q;

  logic [7:0]    cur_op;
  logic [LW-1:0] cur_len, cur_cnt;
  logic          last, legal_now, fit_end;
  logic          chal_d, run_d, rstq_d, chk_d, latch_d;

  function automatic logic legal_fn(input logic [7:0] op, input logic [LW-1:0] len,
                                    input svc_state_e st);
    case (op)
      OP_KEEP: return len == ONE;
      OP_ELEV: return st == ST_IDLE && len >= ELEV_MIN;
      OP_CHAL: return st == ST_ELEV && len == ONE;
      OP_KEY:  return st == ST_CHAL && len == KEY_LEN;
      OP_EXIT: return st != ST_EXIT && len == OFF_END;
      OP_WR:   return st == ST_AUTH && len >= DAT_BEG;
      OP_RUN:  return st == ST_AUTH && len == ONE;
      default: return 1'b0;
    endcase
  endfunction

  assign cur_op    = in_first_i ? in_byte_i : op_q;
  assign cur_len   = in_first_i ? in_len_i  : len_q;
  assign cur_cnt   = in_first_i ? '0        : cnt_q;
  assign last      = in_valid_i && (cur_cnt == cur_len - ONE);
  assign legal_now = in_first_i ? legal_fn(in_byte_i, in_len_i, st_q) : ok_q;

  // payload bytes 1..8 feed one shared shifter: words, exit code or offset
  assign sh_next = (in_valid_i && cur_cnt >= ONE && cur_cnt <= SH_END)
                   ? {sh_q[55:0], in_byte_i} : sh_q;

  assign win_off_o  = (cur_cnt == OFF_END) ? sh_next[31:0] : off_q;
  assign win_dlen_o = cur_len - DAT_BEG;
  assign win_idx_o  = cur_cnt - DAT_BEG;
  assign fit_end    = (cur_cnt == OFF_END) ? win_fit_i : wr_ok_q;

  always_comb begin
    rsp_ld_o  = 1'b0;
    rsp_two_o = 1'b0;
    rsp_b0_o  = NRC_BAD;
    rsp_b1_o  = RSP_ALIVE;
    st_d      = st_q;
    wait_d    = wait_q;
    chal_d    = 1'b0;
    run_d     = 1'b0;
    rstq_d    = 1'b0;
    chk_d     = 1'b0;
    latch_d   = 1'b0;
    if (wait_q && auth_done_i) begin
      rsp_ld_o = 1'b1;
      wait_d   = 1'b0;
      if (auth_pass_i) begin
        rsp_b0_o = RSP_ACK;
        st_d     = ST_AUTH;
      end else begin
        rsp_b0_o = NRC_AUTH;
        st_d     = ST_ELEV;
      end
    end else if (last) begin
      rsp_ld_o = 1'b1;
      if (legal_now) begin
        case (cur_op)
          OP_KEEP: begin
            rsp_b0_o  = RSP_ACK;
            rsp_two_o = 1'b1;
          end
          OP_ELEV: begin
            rsp_b0_o = RSP_ACK;
            st_d     = ST_ELEV;
            latch_d  = 1'b1;
          end
          OP_CHAL: begin
            if (up_ok_i) begin
              rsp_b0_o = RSP_ACK;
              chal_d   = 1'b1;
              st_d     = ST_CHAL;
            end
          end
          OP_KEY: begin
            rsp_ld_o = 1'b0;
            chk_d    = 1'b1;
            wait_d   = 1'b1;
          end
          OP_EXIT: begin
            rsp_b0_o = RSP_ACK;
            if (sh_next[23:0] == EXIT_CODE) begin
              st_d   = ST_EXIT;
              rstq_d = 1'b1;
            end
          end
          OP_WR:   rsp_b0_o = fit_end ? RSP_ACK : NRC_RANGE;
          OP_RUN: begin
            rsp_b0_o = RSP_ACK;
            run_d    = 1'b1;
          end
          default: rsp_b0_o = NRC_BAD;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= ST_IDLE;
      op_q           <= '0;
      len_q          <= '0;
      cnt_q          <= '0;
      ok_q           <= 1'b0;
      wr_ok_q        <= 1'b0;
      wait_q         <= 1'b0;
      sh_q           <= '0;
      off_q          <= '0;
      key_valid_o    <= 1'b0;
      key_byte_o     <= '0;
      auth_check_o   <= 1'b0;
      chal_req_o     <= 1'b0;
      ram_we_o       <= 1'b0;
      ram_addr_o     <= '0;
      ram_wdata_o    <= '0;
      cfg_w0_o       <= '0;
      cfg_w1_o       <= '0;
      rst_req_o      <= 1'b0;
      rst_reason_o   <= '0;
      verify_start_o <= 1'b0;
    end else begin
      st_q           <= st_d;
      wait_q         <= wait_d;
      chal_req_o     <= chal_d;
      verify_start_o <= run_d;
      rst_req_o      <= rstq_d;
      auth_check_o   <= chk_d;
      if (rstq_d) rst_reason_o <= RST_REASON;
      if (latch_d) begin
        cfg_w0_o <= sh_next[63:32];
        cfg_w1_o <= sh_next[31:0];
      end
      if (in_valid_i) begin
        if (in_first_i) begin
          op_q  <= in_byte_i;
          len_q <= in_len_i;
          ok_q  <= legal_fn(in_byte_i, in_len_i, st_q);
        end
        cnt_q <= cur_cnt + ONE;
        sh_q  <= sh_next;
        if (cur_cnt == OFF_END) begin
          off_q   <= sh_next[31:0];
          wr_ok_q <= win_fit_i;
        end
      end
      key_valid_o <= in_valid_i && cur_op == OP_KEY && cur_cnt >= ONE && legal_now;
      key_byte_o  <= in_byte_i;
      // range decided at the last offset byte, before any data byte lands
      ram_we_o    <= in_valid_i && cur_op == OP_WR && cur_cnt >= DAT_BEG && legal_now && wr_ok_q;
      ram_addr_o  <= win_addr_i;
      ram_wdata_o <= in_byte_i;
    end
  end

  AST_WR_IN_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_addr_o >= WIN_BASE && ram_addr_o < WIN_BASE + WIN_SIZE)); // R6
  AST_RUN_AUTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verify_start_o |-> st_q == ST_AUTH); // R10
  AST_CHAL_UPTIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chal_req_o |-> up_ok_i); // R3
  AST_EXIT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_EXIT |=> st_q == ST_EXIT); // R8
  AST_RST_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (st_q == ST_EXIT && $past(st_q) != ST_EXIT)); // R8
  AST_AUTH_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_AUTH && $past(st_q) != ST_AUTH) |-> $past(st_q) == ST_CHAL); // R4
  AST_ELEV_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ELEV && $past(st_q) != ST_ELEV)
      |-> ($past(st_q) == ST_IDLE || $past(st_q) == ST_CHAL)); // R2
endmodule

// File: rtl/svc_shell.sv
module svc_shell #(
  parameter int          LW         = 12,
  parameter int          KEY_BYTES  = 256,
  parameter int          MIN_TICKS  = 100,
  parameter logic [31:0] WIN_BASE   = 32'hB001_0000,
  parameter logic [31:0] WIN_SIZE   = 32'h0000_5000,
  parameter logic [23:0] EXIT_CODE  = 24'h414357,
  parameter logic [15:0] RST_REASON = 16'h0200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          in_first_i,
  input  logic [LW-1:0] in_len_i,
  input  logic [7:0]    in_byte_i,
  input  logic          tick_i,
  input  logic          auth_done_i,
  input  logic          auth_pass_i,
  output logic          rsp_valid_o,
  output logic [7:0]    rsp_byte_o,
  output logic          key_valid_o,
  output logic [7:0]    key_byte_o,
  output logic          auth_check_o,
  output logic          chal_req_o,
  output logic          ram_we_o,
  output logic [31:0]   ram_addr_o,
  output logic [7:0]    ram_wdata_o,
  output logic [31:0]   cfg_w0_o,
  output logic [31:0]   cfg_w1_o,
  output logic          rst_req_o,
  output logic [15:0]   rst_reason_o,
  output logic          verify_start_o
);
  logic          up_ok, win_fit, rsp_ld, rsp_two;
  logic [31:0]   win_addr, win_off;
  logic [LW-1:0] win_dlen, win_idx;
  logic [7:0]    rsp_b0, rsp_b1;

  svc_uptime #(.MIN_TICKS(MIN_TICKS)) u_uptime (
    .clk_i, .rst_ni, .tick_i, .up_ok_o(up_ok)
  );

  svc_win #(.WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE), .LW(LW)) u_win (
    .off_i(win_off), .dlen_i(win_dlen), .idx_i(win_idx),
    .fit_o(win_fit), .addr_o(win_addr)
  );

  svc_fsm #(
    .LW(LW), .KEY_BYTES(KEY_BYTES), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
    .EXIT_CODE(EXIT_CODE), .RST_REASON(RST_REASON)
  ) u_fsm (
    .clk_i, .rst_ni, .in_valid_i, .in_first_i, .in_len_i, .in_byte_i,
    .auth_done_i, .auth_pass_i,
    .up_ok_i(up_ok), .win_fit_i(win_fit), .win_addr_i(win_addr),
    .win_off_o(win_off), .win_dlen_o(win_dlen), .win_idx_o(win_idx),
    .rsp_ld_o(rsp_ld), .rsp_two_o(rsp_two), .rsp_b0_o(rsp_b0), .rsp_b1_o(rsp_b1),
    .key_valid_o, .key_byte_o, .auth_check_o, .chal_req_o,
    .ram_we_o, .ram_addr_o, .ram_wdata_o, .cfg_w0_o, .cfg_w1_o,
    .rst_req_o, .rst_reason_o, .verify_start_o
  );

  svc_rsp u_rsp (
    .clk_i, .rst_ni, .load_i(rsp_ld), .two_i(rsp_two),
    .b0_i(rsp_b0), .b1_i(rsp_b1), .rsp_valid_o, .rsp_byte_o
  );
endmodule

// File: tb/svc_shell_tb.sv
`timescale 1ns/1ps
module svc_shell_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, tick = 1'b0;
  logic [11:0] in_len = '0;
  logic [7:0]  in_byte = '0;
  logic        auth_done = 1'b0, auth_pass = 1'b0;
  logic        rsp_valid, key_valid, auth_check, chal_req, ram_we, rst_req, verify_start;
  logic [7:0]  rsp_byte, key_byte, ram_wdata;
  logic [31:0] ram_addr, cfg_w0, cfg_w1;
  logic [15:0] rst_reason;

  always #2.5 clk = ~clk;

  svc_shell u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_first_i(in_first),
    .in_len_i(in_len), .in_byte_i(in_byte), .tick_i(tick),
    .auth_done_i(auth_done), .auth_pass_i(auth_pass),
    .rsp_valid_o(rsp_valid), .rsp_byte_o(rsp_byte),
    .key_valid_o(key_valid), .key_byte_o(key_byte), .auth_check_o(auth_check),
    .chal_req_o(chal_req), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .cfg_w0_o(cfg_w0), .cfg_w1_o(cfg_w1),
    .rst_req_o(rst_req), .rst_reason_o(rst_reason), .verify_start_o(verify_start)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] fb [0:299];
  logic [7:0] rb [0:511];
  int rn = 0, wn = 0, kn = 0, cn = 0, chn = 0, vn = 0, rqn = 0, rbase = 0;
  logic [31:0] wa0, wal;
  logic [7:0]  wd0, wdl;

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (rn < 512) rb[rn] = rsp_byte;
      rn++;
    end
    if (ram_we) begin
      if (wn == 0) begin wa0 = ram_addr; wd0 = ram_wdata; end
      wal = ram_addr; wdl = ram_wdata; wn++;
    end
    if (key_valid) kn++;
    if (auth_check) cn++;
    if (chal_req) chn++;
    if (verify_start) vn++;
    if (rst_req) rqn++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input int n);
    rbase = rn;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = (i == 0); in_len = 12'(n); in_byte = fb[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_rsp(input string req, input int n, input logic [7:0] b0,
                            input logic [7:0] b1);
    chk({req, " rsp count"}, 32'(rn - rbase), 32'(n));
    chk({req, " rsp byte0"}, {24'h0, rb[rbase]}, {24'h0, b0});
    if (n == 2) chk({req, " rsp byte1"}, {24'h0, rb[rbase+1]}, {24'h0, b1});
  endtask

  task automatic one(input string req, input logic [7:0] op, input logic [7:0] exp);
    fb[0] = op; send(1); expect_rsp(req, 1, exp, 8'h00);
  endtask

  task automatic keep(input string req);
    fb[0] = 8'h6B; send(1); expect_rsp(req, 2, 8'hA0, 8'h02);
  endtask

  task automatic wr(input string req, input logic [31:0] off, input int nd,
                    input logic [7:0] exp, input int expw);
    int w0;
    w0 = wn;
    fb[0] = 8'h78;
    fb[1] = off[31:24]; fb[2] = off[23:16]; fb[3] = off[15:8]; fb[4] = off[7:0];
    for (int i = 0; i < nd; i++) fb[5+i] = 8'(8'hA0 + i);
    send(5 + nd);
    expect_rsp(req, 1, exp, 8'h00);
    chk({req, " writes"}, 32'(wn - w0), 32'(expw));
  endtask

  task automatic key(input string req, input bit pass, input logic [7:0] exp);
    int k0, c0;
    k0 = kn; c0 = cn;
    fb[0] = 8'h65;
    for (int i = 1; i <= 256; i++) fb[i] = 8'(i);
    send(257);
    chk({req, " key bytes"}, 32'(kn - k0), 32'd256);
    chk({req, " check strobes"}, 32'(cn - c0), 32'd1);
    chk({req, " no early rsp"}, 32'(rn - rbase), 32'd0);
    @(negedge clk); auth_done = 1'b1; auth_pass = pass;
    @(negedge clk); auth_done = 1'b0; auth_pass = 1'b0;
    repeat (3) @(negedge clk);
    expect_rsp(req, 1, exp, 8'h00);
  endtask

  task automatic t_reset;
    chk("R11 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R11 ram_we", {31'h0, ram_we}, 32'h0);
    chk("R11 cfg_w0", cfg_w0, 32'h0);
    chk("R11 cfg_w1", cfg_w1, 32'h0);
    chk("R11 reason", {16'h0, rst_reason}, 32'h0);
    chk("R11 strobes", {28'h0, chal_req, verify_start, rst_req, auth_check}, 32'h0);
  endtask

  task automatic t_idle_illegal;
    int w0;
    w0 = wn;
    keep("R1 idle");
    one("R9 challenge in idle", 8'h54, 8'hE1);
    one("R10 run in idle", 8'h79, 8'hE1);
    wr("R10 write in idle", 32'h0, 2, 8'hE1, 0);
    one("R9 unknown opcode", 8'h11, 8'hE1);
    fb[0] = 8'h6B; fb[1] = 8'h00; send(2);
    expect_rsp("R9 keepalive long", 1, 8'hE1, 8'h00);
    fb[0] = 8'h30; for (int i = 1; i < 5; i++) fb[i] = 8'hFF; send(5);
    expect_rsp("R9 elevate short", 1, 8'hE1, 8'h00);
    chk("R9 short no latch", cfg_w0, 32'h0);
    chk("R10 no writes", 32'(wn - w0), 32'h0);
  endtask

  task automatic t_elevate;
    fb[0] = 8'h30;
    for (int i = 1; i <= 11; i++) fb[i] = 8'(8'h11 * i);
    send(12);
    expect_rsp("R2 elevate", 1, 8'hA0, 8'h00);
    chk("R2 word0", cfg_w0, 32'h11223344);
    chk("R2 word1", cfg_w1, 32'h55667788);
    fb[0] = 8'h30; for (int i = 1; i <= 8; i++) fb[i] = 8'h00; send(9);
    expect_rsp("R9 elevate twice", 1, 8'hE1, 8'h00);
    chk("R9 words kept", cfg_w0, 32'h11223344);
  endtask

  task automatic t_uptime;
    for (int i = 0; i < 99; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
    one("R3 challenge at 99 ticks", 8'h54, 8'hE1);
    chk("R3 no request", 32'(chn), 32'h0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    one("R3 challenge at 100 ticks", 8'h54, 8'hA0);
    chk("R3 one request", 32'(chn), 32'h1);
  endtask

  task automatic t_auth;
    key("R4 key fail", 1'b0, 8'hE3);
    key_short();
    one("R10 run after fail", 8'h79, 8'hE1);
    one("R3 rechallenge", 8'h54, 8'hA0);
    keep("R1 challenged");
    key("R4 key pass", 1'b1, 8'hA0);
    one("R9 challenge when authorised", 8'h54, 8'hE1);
  endtask

  task automatic key_short;
    fb[0] = 8'h65; for (int i = 1; i <= 10; i++) fb[i] = 8'h00; send(11);
    expect_rsp("R9 key in wrong state", 1, 8'hE1, 8'h00);
  endtask

  task automatic t_write;
    wr("R5 write", 32'h0000_0010, 3, 8'hA0, 3);
    chk("R5 first addr", wa0, 32'hB001_0010);
    chk("R5 first data", {24'h0, wd0}, 32'hA0);
    chk("R5 last addr", wal, 32'hB001_0012);
    chk("R5 last data", {24'h0, wdl}, 32'hA2);
    wr("R6 exact end", 32'h0000_4FFE, 2, 8'hA0, 2);
    chk("R6 end addr", wal, 32'hB001_4FFF);
    wr("R6 past end", 32'h0000_4FFE, 3, 8'hE2, 0);
    wr("R6 wrap offset", 32'hFFFF_FFFF, 1, 8'hE2, 0);
  endtask

  task automatic t_run_exit;
    one("R7 run", 8'h79, 8'hA0);
    chk("R7 verify strobe", 32'(vn), 32'h1);
    fb[0] = 8'h79; fb[1] = 8'h00; send(2);
    expect_rsp("R9 run long", 1, 8'hE1, 8'h00);
    chk("R7 no extra strobe", 32'(vn), 32'h1);
    fb[0] = 8'h7D; fb[1] = 8'h4E; fb[2] = 8'h42; fb[3] = 8'h30; send(4);
    expect_rsp("R8 other code", 1, 8'hA0, 8'h00);
    chk("R8 no reset", 32'(rqn), 32'h0);
    one("R8 state kept", 8'h79, 8'hA0);
    fb[0] = 8'h7D; fb[1] = 8'h41; fb[2] = 8'h43; fb[3] = 8'h57; send(4);
    expect_rsp("R8 exit", 1, 8'hA0, 8'h00);
    chk("R8 reset request", 32'(rqn), 32'h1);
    chk("R8 reason", {16'h0, rst_reason}, 32'h200);
    one("R10 run after exit", 8'h79, 8'hE1);
    keep("R1 exit state");
    fb[0] = 8'h7D; send(4);
    expect_rsp("R9 exit again", 1, 8'hE1, 8'h00);
    chk("R8 single request", 32'(rqn), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_idle_illegal();
    t_elevate();
    t_uptime();
    t_auth();
    t_write();
    t_run_exit();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule